// File: doc/BRIEF.md
# Key Hierarchy Stage Controller

This block is the sequencing core of a key-derivation unit. It holds the current position of a key hierarchy on a fixed ladder of stages and runs one software-requested operation at a time. An operation starts with a one-cycle go strobe that carries a 3-bit operation code. While the operation runs, the configuration-enable output is low. Operations that need new key material raise a level request toward an external derivation engine and wait for its done strobe. Operations that the controller can settle alone finish after one evaluation cycle.

When an operation finishes, the controller updates several outputs together: the stage, a 2-bit status, three sticky error bits and the software-binding write enable. It also pulses a completion interrupt for one cycle. Generate operations that ask for an output key compare the supplied key version against a per-stage maximum held in the block. A fault or a global escalation input sends the controller to a terminal Invalid stage at any time. If an operation is in flight when that happens, the operation is aborted with an error.

Top module: `keyladder_ctrl`

## Requirements
- R1: After reset, stage_o is 0 (Reset), status_o is 0, err_o is 0, cfg_en_o is 1, bind_en_o is 1, done_irq_o is 0 and drv_req_o is 0. The stage codes are: 0 Reset, 1 Init, 2 CreatorRoot, 3 OwnerIntermediate, 4 Owner, 5 Disabled, 6 Invalid.
- R2: Operation code 0 is advance. From Reset, advance moves to Init with no derivation request. From Init, CreatorRoot or OwnerIntermediate, advance raises drv_req_o. A done strobe without an error then moves the stage up by one and ends with success.
- R3: The following all move the stage to Disabled with success and no derivation request: advance from Owner, operation code 4, and codes 5, 6 and 7.
- R4: In Disabled, every operation code ends with done-with-error, sets error bit 0, and leaves the stage unchanged.
- R5: fault_i or escalate_i moves the stage to Invalid on the next edge. Invalid is left only by reset. An operation in flight ends at that same edge with status 3, a done pulse, and drv_req_o low. Any operation issued in Invalid ends with error bit 0 set.
- R6: go_i is accepted only while cfg_en_o is 1. cfg_en_o reads 0 from the edge after acceptance until the edge where the operation finishes. A go_i pulse while cfg_en_o is 0 has no effect.
- R7: The status codes are: 0 idle, 1 in progress, 2 done with success, 3 done with error. Status shows 1 while an operation runs. Each bit is cleared by writing 1 to the matching bit of status_clr_i. done_irq_o pulses for exactly one cycle when an operation finishes.
- R8: The error bits are: bit 0 invalid operation, bit 1 invalid derivation input, bit 2 shadow update error. Bit 2 is set by shadow_err_i. Every bit is sticky and is cleared by writing 1 to the matching bit of err_clr_i.
- R9: Generate codes 1, 2 and 3 issued in Reset or Init end with done-with-error, set error bit 0, and raise no derivation request.
- R10: bind_en_o is cleared by a bind_lock_i pulse. Only a successful advance to a higher non-terminal stage sets it back to 1. Generate and disable leave it unchanged.
- R11: Codes 2 and 3 (software or hardware output) proceed only when key_ver_i is at most the maximum for the current stage. The maximums are: slot 0 CreatorRoot, reset value 0; slot 1 OwnerIntermediate, reset value 1; slot 2 Owner, reset value 0. Each slot is written through max_we_i[slot]. A version above the maximum ends with error, sets error bit 1, and raises no request. Code 1 does not check the version.
- R12: A done strobe that arrives with drv_err_i high moves the stage to Invalid and ends the operation with status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | One-cycle operation launch strobe |
| op_i | input | 3 | Operation code sampled with go_i |
| cfg_en_o | output | 1 | Configuration enable, low while an operation runs |
| stage_o | output | 3 | Current hierarchy stage |
| status_o | output | 2 | Operation status |
| status_clr_i | input | 2 | Write-1-to-clear for status bits |
| err_o | output | 3 | Sticky error bits |
| err_clr_i | input | 3 | Write-1-to-clear for error bits |
| shadow_err_i | input | 1 | Shadow register update error event |
| done_irq_o | output | 1 | One-cycle completion pulse |
| bind_en_o | output | 1 | Software-binding write enable |
| bind_lock_i | input | 1 | Software request to clear bind_en_o |
| key_ver_i | input | VER_W | Requested key version |
| max_we_i | input | 3 | Write strobes for the three version maximums |
| max_wdata_i | input | VER_W | Write data for the version maximums |
| drv_req_o | output | 1 | Derivation request, held until done |
| drv_op_o | output | 3 | Operation code presented with the request |
| drv_done_i | input | 1 | Derivation done strobe |
| drv_err_i | input | 1 | Derivation error, valid with done |
| fault_i | input | 1 | Internal fault detected |
| escalate_i | input | 1 | Global escalation |

## Verification
A corrupted stage register shows up on stage_o at the next edge. It also shows up one cycle after a go strobe: a wrong stage sends the request line or the error bits the wrong way, so a misrouted advance or generate is visible within the first evaluation cycle. A stuck or mis-sequenced phase register shows as cfg_en_o failing to drop the cycle after go, as done_irq_o lasting more than one cycle, or as drv_req_o staying high after done. Every operation's final stage, status and error bits are compared at the cycle of its completion pulse. A wrongly kept or released binding lock is visible on bind_en_o right after completion.

// File: rtl/keyladder_ctrl.sv
module keyladder_ctrl #(
  parameter int VER_W = 32,
  parameter logic [VER_W-1:0] CREATOR_MAX_RST = '0,
  parameter logic [VER_W-1:0] OWNER_INT_MAX_RST = 1,
  parameter logic [VER_W-1:0] OWNER_MAX_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [2:0]       op_i,
  output logic             cfg_en_o,
  output logic [2:0]       stage_o,
  output logic [1:0]       status_o,
  input  logic [1:0]       status_clr_i,
  output logic [2:0]       err_o,
  input  logic [2:0]       err_clr_i,
  input  logic             shadow_err_i,
  output logic             done_irq_o,
  output logic             bind_en_o,
  input  logic             bind_lock_i,
  input  logic [VER_W-1:0] key_ver_i,
  input  logic [2:0]       max_we_i,
  input  logic [VER_W-1:0] max_wdata_i,
  output logic             drv_req_o,
  output logic [2:0]       drv_op_o,
  input  logic             drv_done_i,
  input  logic             drv_err_i,
  input  logic             fault_i,
  input  logic             escalate_i
);

  localparam logic [2:0] S_RESET = 3'd0, S_INIT = 3'd1, S_CREATOR = 3'd2,
                         S_OWN_INT = 3'd3, S_OWNER = 3'd4, S_DIS = 3'd5, S_INV = 3'd6;
  localparam logic [2:0] OP_ADV = 3'd0, OP_ID = 3'd1, OP_SW = 3'd2, OP_HW = 3'd3;
  localparam int NSLOT = 3;

  typedef enum logic [1:0] {P_IDLE, P_EVAL, P_WAIT} phase_e;

  phase_e            phase_q, nxt_phase;
  logic [2:0]        stage_q, nxt_stage, op_q, err_q, set_err;
  logic [1:0]        status_q;
  logic              irq_q, bind_q, fin, fin_bad, reopen, go_acc, kill;
  logic [VER_W-1:0]  max_q [NSLOT];
  logic [VER_W-1:0]  cur_max;
  logic              is_adv, is_gen, is_out, terminal, key_stage, ver_bad;

  assign go_acc    = go_i && (phase_q == P_IDLE);
  assign kill      = fault_i || escalate_i;
  assign is_adv    = (op_q == OP_ADV);
  assign is_gen    = (op_q == OP_ID) || (op_q == OP_SW) || (op_q == OP_HW);
  assign is_out    = (op_q == OP_SW) || (op_q == OP_HW);
  assign terminal  = (stage_q == S_DIS) || (stage_q == S_INV);
  assign key_stage = (stage_q == S_CREATOR) || (stage_q == S_OWN_INT) || (stage_q == S_OWNER);

  always_comb begin
    case (stage_q)
      S_CREATOR: cur_max = max_q[0];
      S_OWN_INT: cur_max = max_q[1];
      default:   cur_max = max_q[2];
    endcase
  end

  assign ver_bad = is_out && (key_ver_i > cur_max);

  always_comb begin
    nxt_stage = stage_q;
    nxt_phase = phase_q;
    fin       = 1'b0;
    fin_bad   = 1'b0;
    set_err   = '0;
    reopen    = 1'b0;
    case (phase_q)
      P_IDLE: if (go_i) nxt_phase = P_EVAL;
      P_EVAL: begin
        nxt_phase = P_IDLE;
        fin       = 1'b1;
        if (terminal || (is_gen && !key_stage)) begin
          fin_bad    = 1'b1;
          set_err[0] = 1'b1;
        end else if (is_gen && ver_bad) begin
          fin_bad    = 1'b1;
          set_err[1] = 1'b1;
        end else if (is_gen) begin
          fin       = 1'b0;
          nxt_phase = P_WAIT;
        end else if (!is_adv || stage_q == S_OWNER) begin
          nxt_stage = S_DIS;
        end else if (stage_q == S_RESET) begin
          nxt_stage = S_INIT;
          reopen    = 1'b1;
        end else begin
          fin       = 1'b0;
          nxt_phase = P_WAIT;
        end
      end
      P_WAIT: begin
        if (drv_done_i) begin
          nxt_phase = P_IDLE;
          fin       = 1'b1;
          if (drv_err_i) begin
            fin_bad   = 1'b1;
            nxt_stage = S_INV;
          end else if (is_adv) begin
            nxt_stage = stage_q + 3'd1;
            reopen    = 1'b1;
          end
        end
      end
      default: nxt_phase = P_IDLE;
    endcase
    if (kill) begin
      nxt_stage = S_INV;
      reopen    = 1'b0;
      if (phase_q != P_IDLE) begin
        fin       = 1'b1;
        fin_bad   = 1'b1;
        nxt_phase = P_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= P_IDLE;
      stage_q  <= S_RESET;
      op_q     <= '0;
      status_q <= '0;
      err_q    <= '0;
      irq_q    <= 1'b0;
      bind_q   <= 1'b1;
      max_q[0] <= CREATOR_MAX_RST;
      max_q[1] <= OWNER_INT_MAX_RST;
      max_q[2] <= OWNER_MAX_RST;
    end else begin
      phase_q <= nxt_phase;
      stage_q <= nxt_stage;
      irq_q   <= fin;
      if (go_acc) op_q <= op_i;
      if (go_acc)   status_q <= 2'd1;
      else if (fin) status_q <= fin_bad ? 2'd3 : 2'd2;
      else          status_q <= status_q & ~status_clr_i;
      err_q <= (err_q & ~err_clr_i) | set_err | {shadow_err_i, 2'b00};
      if (reopen)           bind_q <= 1'b1;
      else if (bind_lock_i) bind_q <= 1'b0;
      for (int i = 0; i < NSLOT; i++)
        if (max_we_i[i]) max_q[i] <= max_wdata_i;
    end
  end

  assign cfg_en_o   = (phase_q == P_IDLE);
  assign stage_o    = stage_q;
  assign status_o   = status_q;
  assign err_o      = err_q;
  assign done_irq_o = irq_q;
  assign bind_en_o  = bind_q;
  assign drv_req_o  = (phase_q == P_WAIT);
  assign drv_op_o   = op_q;

  assert_stage_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o <= S_INV);

  assert_ladder_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o <= S_OWNER && !kill) |=>
      (stage_o == $past(stage_o) || stage_o == $past(stage_o) + 3'd1 ||
       stage_o == S_DIS || stage_o == S_INV));

  assert_disabled_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == S_DIS && !kill) |=> stage_o == S_DIS);

  assert_invalid_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == S_INV |=> stage_o == S_INV);

  assert_kill_invalid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |=> stage_o == S_INV);

  assert_go_locks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && cfg_en_o) |=> (!cfg_en_o && status_o == 2'd1));

  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);

  assert_irq_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> status_o[1]);

  assert_gen_stage_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_req_o && drv_op_o != OP_ADV) |-> (stage_o >= S_CREATOR && stage_o <= S_OWNER));

  assert_bind_reopen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bind_en_o |=> (!bind_en_o || (done_irq_o && status_o == 2'd2)));

endmodule

// File: tb/tb_keyladder_ctrl.sv
module tb_keyladder_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 32;

  typedef struct packed {
    logic [2:0] st;
    logic [1:0] ss;
    logic [2:0] er;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic go = 0; logic [2:0] op = 0;
  logic cfg_en; logic [2:0] stage; logic [1:0] status; logic [1:0] st_clr = 0;
  logic [2:0] err; logic [2:0] er_clr = 0; logic shadow = 0;
  logic irq, bind_en, bind_lock = 0;
  logic [VW-1:0] kver = 0; logic [2:0] max_we = 0; logic [VW-1:0] max_wd = 0;
  logic req; logic [2:0] dop; logic done = 0, derr = 0, fault = 0, esc = 0;

  int total = 0, bad = 0;
  exp_t expq[$];
  string tagq[$];
  bit hold = 0, err_set = 0, saw_req = 0;

  keyladder_ctrl #(.VER_W(VW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .op_i(op), .cfg_en_o(cfg_en),
    .stage_o(stage), .status_o(status), .status_clr_i(st_clr), .err_o(err),
    .err_clr_i(er_clr), .shadow_err_i(shadow), .done_irq_o(irq), .bind_en_o(bind_en),
    .bind_lock_i(bind_lock), .key_ver_i(kver), .max_we_i(max_we), .max_wdata_i(max_wd),
    .drv_req_o(req), .drv_op_o(dop), .drv_done_i(done), .drv_err_i(derr),
    .fault_i(fault), .escalate_i(esc));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // responder: answers a request after a short delay unless held
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      done = 0; derr = 0;
      if (req) begin
        saw_req = 1;
        if (!hold) begin
          if (cnt == 2) begin done = 1; derr = err_set; cnt = 0; end
          else cnt++;
        end
      end else cnt = 0;
    end
  end

  // monitor: compares each completion against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (irq) begin
        if (expq.size() == 0) chk("R7 unexpected completion", 1, 0);
        else begin
          exp_t e; string t;
          e = expq.pop_front(); t = tagq.pop_front();
          chk({t, " stage"}, stage, e.st);
          chk({t, " status"}, status, e.ss);
          chk({t, " err"}, err, e.er);
        end
      end
    end
  end

  task automatic push(input logic [2:0] s, input logic [1:0] ss, input logic [2:0] e, input string t);
    exp_t x; x.st = s; x.ss = ss; x.er = e;
    expq.push_back(x); tagq.push_back(t);
  endtask

  task automatic wait_irq(input string t);
    int n = 0;
    while (!irq && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) chk({t, " completion timeout"}, 0, 1);
  endtask

  task automatic run_op(input logic [2:0] o, input logic [2:0] s, input logic [1:0] ss,
                        input logic [2:0] e, input bit r, input string t);
    push(s, ss, e, t);
    saw_req = 0;
    op = o; go = 1;
    @(negedge clk); go = 0;
    chk({t, " R6 cfg_en low"}, cfg_en, 0);
    chk({t, " R7 status busy"}, status, 1);
    wait_irq(t);
    chk({t, " request seen"}, saw_req, r);
    @(negedge clk);
    chk({t, " R7 irq single"}, irq, 0);
    chk({t, " R6 cfg_en back"}, cfg_en, 1);
  endtask

  task automatic clr_all();
    st_clr = 2'b11; er_clr = 3'b111;
    @(negedge clk); st_clr = 0; er_clr = 0;
    chk("R7 status w1c", status, 0);
    chk("R8 err w1c", err, 0);
  endtask

  task automatic do_reset();
    rst_n = 0; hold = 0; err_set = 0; kver = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic lock_bind();
    bind_lock = 1; @(negedge clk); bind_lock = 0;
    chk("R10 bind cleared", bind_en, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 stage", stage, 0); chk("R1 status", status, 0); chk("R1 err", err, 0);
    chk("R1 cfg_en", cfg_en, 1); chk("R1 bind", bind_en, 1);
    chk("R1 irq", irq, 0); chk("R1 req", req, 0);

    run_op(3'd1, 3'd0, 2'd3, 3'b001, 0, "R9 gen in Reset");
    clr_all();
    lock_bind();
    run_op(3'd0, 3'd1, 2'd2, 3'b000, 0, "R2 Reset->Init");
    chk("R10 bind reopened", bind_en, 1);
    run_op(3'd2, 3'd1, 2'd3, 3'b001, 0, "R9 gen in Init");
    clr_all();
    run_op(3'd0, 3'd2, 2'd2, 3'b000, 1, "R2 Init->Creator");
    lock_bind();
    run_op(3'd1, 3'd2, 2'd2, 3'b000, 1, "R10 gen id");
    chk("R10 bind stays after gen", bind_en, 0);

    kver = 0;
    run_op(3'd2, 3'd2, 2'd2, 3'b000, 1, "R11 ver at creator max");
    kver = 1;
    run_op(3'd2, 3'd2, 2'd3, 3'b010, 0, "R11 ver over creator max");
    clr_all();
    max_we = 3'b001; max_wd = 5; @(negedge clk); max_we = 0;
    run_op(3'd3, 3'd2, 2'd2, 3'b000, 1, "R11 hw out after max write");
    kver = 100;
    run_op(3'd1, 3'd2, 2'd2, 3'b000, 1, "R11 id ignores version");
    kver = 1;
    run_op(3'd0, 3'd3, 2'd2, 3'b000, 1, "R2 Creator->OwnerInt");
    chk("R10 bind reopened by advance", bind_en, 1);
    run_op(3'd2, 3'd3, 2'd2, 3'b000, 1, "R11 ownerint max 1");
    kver = 2;
    run_op(3'd2, 3'd3, 2'd3, 3'b010, 0, "R11 over ownerint max");
    clr_all();

    // R6: go while busy is ignored
    hold = 1; push(3'd4, 2'd2, 3'b000, "R6 busy go ignored");
    op = 3'd0; go = 1; @(negedge clk); go = 0;
    while (!req) @(negedge clk);
    op = 3'd4; go = 1; @(negedge clk); go = 0;
    chk("R6 cfg_en stays low", cfg_en, 0);
    chk("R6 drv_op unchanged", dop, 0);
    hold = 0;
    wait_irq("R6 busy");
    @(negedge clk);
    chk("R6 stage owner", stage, 4);

    run_op(3'd0, 3'd5, 2'd2, 3'b000, 0, "R3 advance from Owner");
    run_op(3'd0, 3'd5, 2'd3, 3'b001, 0, "R4 advance in Disabled");
    run_op(3'd4, 3'd5, 2'd3, 3'b001, 0, "R4 disable in Disabled");
    st_clr = 2'b01; @(negedge clk); st_clr = 0;
    chk("R7 partial w1c", status, 2);
    clr_all();
    shadow = 1; @(negedge clk); shadow = 0;
    chk("R8 shadow bit", err, 3'b100);
    @(negedge clk);
    chk("R8 shadow sticky", err, 3'b100);
    er_clr = 3'b100; @(negedge clk); er_clr = 0;
    chk("R8 shadow cleared", err, 0);

    do_reset();
    run_op(3'd0, 3'd1, 2'd2, 3'b000, 0, "R2 Reset->Init");
    run_op(3'd7, 3'd5, 2'd2, 3'b000, 0, "R3 code 7 disables");
    do_reset();
    run_op(3'd0, 3'd1, 2'd2, 3'b000, 0, "R2 Reset->Init");
    run_op(3'd4, 3'd5, 2'd2, 3'b000, 0, "R3 code 4 disables");

    do_reset();
    run_op(3'd0, 3'd1, 2'd2, 3'b000, 0, "R2 Reset->Init");
    err_set = 1;
    run_op(3'd0, 3'd6, 2'd3, 3'b000, 1, "R12 engine error");
    err_set = 0;
    run_op(3'd1, 3'd6, 2'd3, 3'b001, 0, "R5 op in Invalid");

    do_reset();
    run_op(3'd0, 3'd1, 2'd2, 3'b000, 0, "R2 Reset->Init");
    hold = 1; push(3'd6, 2'd3, 3'b000, "R5 fault in flight");
    op = 3'd0; go = 1; @(negedge clk); go = 0;
    while (!req) @(negedge clk);
    fault = 1; @(negedge clk); fault = 0;
    chk("R5 irq on abort", irq, 1);
    chk("R5 request dropped", req, 0);
    hold = 0;
    @(negedge clk);
    chk("R5 stays Invalid", stage, 6);

    do_reset();
    esc = 1; @(negedge clk); esc = 0;
    chk("R5 escalate idle", stage, 6);
    chk("R5 no irq when idle", irq, 0);
    repeat (3) @(negedge clk);
    chk("R5 Invalid sticky", stage, 6);

    chk("scoreboard drained", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule